// File: doc/BRIEF.md
# Sampled-Clock Memory Write Port

This block is a small register-file memory whose write port belongs to a slower or irregular design clock, while every flop inside it runs on one fast global sampling clock. The design write clock is treated as plain data: it is sampled each global cycle, and a write is committed only in the global cycle where the sampled value shows an active edge of the chosen polarity. The write mask, address and data are registered one global cycle ahead of that point. The write therefore uses the values that were present just before the design clock moved. This is the setup-time view that a real clocked port would have.

Read ports are combinational: they show the current array contents at once, with no clock. A parameter picks rising-edge or falling-edge operation. Further parameters set the address width, the data width and the number of read ports. A clocked read port is not part of this block.

Top module: `sampled_wport_mem`

## Requirements
- R1: While `rst_n` is low, every array word is cleared to zero. No write happens during reset.
- R2: A write is committed on the global edge that ends a cycle in which `wr_clk` is at the active level and the sample taken on the previous global edge was at the inactive level. The active level is 1 for `RISING`=1 and 0 for `RISING`=0.
- R3: Reset sets the previous-clock sample to the active level. If `wr_clk` sits at the active level through reset and afterwards, no write takes place.
- R4: The mask, address and data used by a write are the values sampled one global edge before the commit. Changes to these inputs in the cycle where the design edge appears do not affect that write.
- R5: A committed write is visible on the read ports right after the global edge that commits it.
- R6: `wr_mask` is a per-bit mask as wide as the data word. Bit i set means bit i of the addressed word takes `wr_data[i]`. Bits with a clear mask bit keep their old value, and a zero mask changes nothing.
- R7: Each design-clock edge gives exactly one write. While `wr_clk` holds either level, no write happens, whatever the other write inputs do.
- R8: Each read port is combinational from its address to its data. In a cycle with a write pending, it returns the old contents until the commit edge.
- R9: The read ports are independent. Port k uses bits [k*ADDR_W +: ADDR_W] of `rd_addr` and drives bits [k*DATA_W +: DATA_W] of `rd_data`.
- R10: With `RISING`=0, a write follows a 1-to-0 change of `wr_clk` only. A 0-to-1 change writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global sampling clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_clk | input | 1 | Design write clock, sampled as data |
| wr_mask | input | DATA_W | Per-bit write enable |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | RD_PORTS*ADDR_W | Packed read addresses, port 0 in the low bits |
| rd_data | output | RD_PORTS*DATA_W | Packed read data, port 0 in the low bits |

## Verification
The write inputs are presented with `wr_clk` inactive. Then `wr_clk` is moved to the active level for one global cycle, and the array changes on the global edge that ends that cycle, which is the second edge after the data was presented. The bench drives inputs on the falling global edge. It checks the read ports half a cycle after a commit edge, and a short delay after it changes a read address, because the read path has no register. The pre-commit checks are taken in the cycle where the edge is already visible, before the commit edge, and confirm that the old word is still returned.

// File: rtl/swm_pkg.sv
package swm_pkg;

    typedef enum logic {
        SWM_FALL = 1'b0,
        SWM_RISE = 1'b1
    } swm_edge_e;

    // Active edge: current sample at the active level, previous one not.
    function automatic logic swm_edge_hit(logic cur, logic prev, swm_edge_e pol);
        logic act;
        act = (pol == SWM_RISE);
        return (cur == act) && (prev != act);
    endfunction

endpackage

// File: rtl/swm_edge_det.sv
module swm_edge_det
    import swm_pkg::*;
#(
    parameter swm_edge_e POL = SWM_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_clk,
    output logic edge_o
);

    typedef struct packed {
        logic prev;
    } det_st_t;

    det_st_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = wr_clk;
        edge_o     = swm_edge_hit(wr_clk, det_q.prev, POL);
    end

    // Start at the active level so a clock already there is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '{prev: (POL == SWM_RISE)};
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/swm_wr_stage.sv
module swm_wr_stage #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stg_st_t;

    stg_st_t stg_d, stg_q;

    always_comb begin
        stg_d      = stg_q;
        stg_d.mask = mask_i;
        stg_d.addr = addr_i;
        stg_d.data = data_i;
        we_o       = edge_i ? stg_q.mask : '0;
        addr_o     = stg_q.addr;
        data_o     = stg_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

endmodule

// File: rtl/swm_array.sv
module swm_array #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RD_PORTS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DATA_W-1:0]            we_i,
    input  logic [ADDR_W-1:0]            waddr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [RD_PORTS*ADDR_W-1:0]   raddr_i,
    output logic [RD_PORTS*DATA_W-1:0]   rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] words;
    } arr_st_t;

    arr_st_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        arr_d.words[waddr_i] = (arr_q.words[waddr_i] & ~we_i) | (wdata_i & we_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        logic [ADDR_W-1:0] ra;
        assign ra = raddr_i[p*ADDR_W +: ADDR_W];
        assign rdata_o[p*DATA_W +: DATA_W] = arr_q.words[ra];
    end

endmodule

// File: rtl/sampled_wport_mem.sv
module sampled_wport_mem
    import swm_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RD_PORTS = 2,
    parameter bit RISING   = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_clk,
    input  logic [DATA_W-1:0]          wr_mask,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [RD_PORTS*ADDR_W-1:0] rd_addr,
    output logic [RD_PORTS*DATA_W-1:0] rd_data
);

    localparam swm_edge_e POL = RISING ? SWM_RISE : SWM_FALL;

    logic              edge_seen;
    logic [DATA_W-1:0] we_eff;
    logic [ADDR_W-1:0] waddr_q;
    logic [DATA_W-1:0] wdata_q;

    swm_edge_det #(
        .POL (POL)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_clk (wr_clk),
        .edge_o (edge_seen)
    );

    swm_wr_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_seen),
        .mask_i (wr_mask),
        .addr_i (wr_addr),
        .data_i (wr_data),
        .we_o   (we_eff),
        .addr_o (waddr_q),
        .data_o (wdata_q)
    );

    swm_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RD_PORTS (RD_PORTS)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_eff),
        .waddr_i (waddr_q),
        .wdata_i (wdata_q),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

endmodule

// File: rtl/swm_mem_chk.sv
module swm_mem_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter bit RISING = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_clk,
    input logic [DATA_W-1:0] wr_mask,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              edge_seen,
    input logic [DATA_W-1:0] we_eff,
    input logic [ADDR_W-1:0] waddr_q
);

    // R2
    edge_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |-> (wr_clk == RISING) && ($past(wr_clk) != RISING));

    // R7
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> !edge_seen);

    // R7
    no_idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_eff != '0) |-> edge_seen);

    // R4
    mask_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |-> (we_eff == $past(wr_mask)));

    // R4
    addr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |-> (waddr_q == $past(wr_addr)));

endmodule

bind sampled_wport_mem swm_mem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RISING (RISING)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_clk    (wr_clk),
    .wr_mask   (wr_mask),
    .wr_addr   (wr_addr),
    .edge_seen (edge_seen),
    .we_eff    (we_eff),
    .waddr_q   (waddr_q)
);

// File: tb/sampled_wport_mem_bench.sv
module sampled_wport_mem_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk_r = 1'b1;
    logic       wclk_f = 1'b0;
    logic [7:0] mask = 8'hFF;
    logic [3:0] addr = 4'd5;
    logic [7:0] data = 8'hEE;
    logic [7:0] raddr = 8'h00;
    logic [15:0] rdat_r, rdat_f;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [16];

    always #4 clk = ~clk;

    sampled_wport_mem u_sampled_wport_mem (
        .clk(clk), .rst_n(rst_n), .wr_clk(wclk_r), .wr_mask(mask),
        .wr_addr(addr), .wr_data(data), .rd_addr(raddr), .rd_data(rdat_r)
    );

    sampled_wport_mem #(.RISING(1'b0)) u_sampled_wport_mem_fall (
        .clk(clk), .rst_n(rst_n), .wr_clk(wclk_f), .wr_mask(mask),
        .wr_addr(addr), .wr_data(data), .rd_addr(raddr), .rd_data(rdat_f)
    );

    // [27:24] addr, [23:16] data, [15:8] mask, [7:0] expected word
    localparam logic [27:0] VECS [0:7] = '{
        28'h3_A5_FF_A5, 28'h3_FF_0F_AF, 28'h7_3C_FF_3C, 28'h7_00_F0_0C,
        28'h0_81_81_81, 28'hF_FF_00_00, 28'hF_5A_FF_5A, 28'h3_00_80_2F
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a0, logic [3:0] a1);
        raddr = {a1, a0};
        #1;
    endtask

    task automatic wr_rise(logic [3:0] a, logic [7:0] d, logic [7:0] m);
        @(negedge clk);
        wclk_r = 1'b0; addr = a; data = d; mask = m;
        @(negedge clk);
        wclk_r = 1'b1; data = ~d; mask = 8'hFF; addr = a;
        @(negedge clk);
        for (int i = 0; i < 8; i++) if (m[i]) model[a][i] = d[i];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 / R3: reset clears, clock held active writes nothing
        rd(4'd5, 4'd0);
        chk("R3 rise", rdat_r[7:0], 8'h00);
        chk("R1", rdat_r[15:8], 8'h00);
        chk("R3 fall", rdat_f[7:0], 8'h00);

        // Table walk: R2 R4 R5 R6 R9
        for (int v = 0; v < 8; v++) begin
            logic [27:0] e;
            e = VECS[v];
            wr_rise(e[27:24], e[23:16], e[15:8]);
            rd(e[27:24], e[27:24] + 4'd4);
            chk("R6 table", rdat_r[7:0], e[7:0]);
            chk("R9 port1", rdat_r[15:8], model[e[27:24] + 4'd4]);
        end

        // R8: combinational read follows address without a clock edge
        rd(4'd7, 4'd0);
        chk("R8 comb p0", rdat_r[7:0], 8'h0C);
        rd(4'd0, 4'd7);
        chk("R8 comb p1", rdat_r[15:8], 8'h0C);

        // R8 / R5: old data until the commit edge
        @(negedge clk);
        wclk_r = 1'b0; addr = 4'd4; data = 8'h99; mask = 8'hFF;
        @(negedge clk);
        wclk_r = 1'b1;
        rd(4'd4, 4'd4);
        chk("R8 old data", rdat_r[7:0], 8'h00);
        @(negedge clk);
        chk("R5 commit", rdat_r[7:0], 8'h99);
        model[4] = 8'h99;

        // R7: idle clock high, then idle low, inputs moving
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            addr = 4'd9; data = 8'(i * 37 + 1); mask = 8'hFF;
        end
        @(negedge clk) wclk_r = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            addr = 4'd9; data = 8'(i * 53 + 2); mask = 8'hFF;
        end
        rd(4'd9, 4'd9);
        chk("R7 idle", rdat_r[7:0], 8'h00);

        // R7: one write per edge, clock then held high
        wr_rise(4'd9, 8'h11, 8'hFF);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            addr = 4'd9; data = 8'(8'h40 + i); mask = 8'hFF;
        end
        rd(4'd9, 4'd9);
        chk("R7 once", rdat_r[7:0], 8'h11);

        // R10: falling instance untouched by the rising traffic
        rd(4'd3, 4'd7);
        chk("R10 no rise traffic", rdat_f[7:0], 8'h00);

        // R10: 0-to-1 writes nothing, 1-to-0 writes
        @(negedge clk);
        wclk_f = 1'b1; addr = 4'd2; data = 8'h77; mask = 8'hFF;
        @(negedge clk);
        rd(4'd2, 4'd2);
        chk("R10 rising ignored", rdat_f[7:0], 8'h00);
        wclk_f = 1'b0; data = 8'h00;
        @(negedge clk);
        chk("R10 fall write", rdat_f[7:0], 8'h77);
        chk("R10 rise inst", rdat_r[7:0], 8'h00);

        // R1: reset clears written words
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        rd(4'd3, 4'd2);
        chk("R1 rise", rdat_r[7:0], 8'h00);
        chk("R1 fall", rdat_f[15:8], 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule